// File: doc/BRIEF.md
# Nine-Bit Multicycle Processor with Error-Gated Branch

This block is a small stored-program processor. One 32-word by 9-bit synchronous memory holds both its program and its data. The core has two 9-bit working registers (A and B), a 5-bit program counter, a 9-bit instruction register and a single error flag. Each instruction goes through a fetch phase, a decode phase and an execute phase.

The core runs five instructions. Load and store move words between memory and a register. Subtract computes A minus B, clamps the result to zero on underflow and raises the error flag. A conditional jump is taken only when that flag is set. Stop ends the program. Any other opcode halts the core and raises a dedicated output.

A debug port gives access to the memory and the registers. While the port is enabled the core is frozen, so a program can be preloaded, the registers seeded, and the full state read back after the core halts. Reset loads the program counter from an input, so the same memory image can be entered at any address.

Top module: `cpu9_core`

## Requirements
- R1: When synchronous reset is sampled high, the core loads the program counter from `start_addr` and clears A, B and the error flag. After reset is released, `halted` and `illegal_op` read 0.
- R2: An instruction word has the opcode in bits [8:6], the register select in bit [5] (0 = A, 1 = B) and the operand in bits [4:0]. Load (opcode 010) copies the memory word at the operand address into the selected register.
- R3: Store (opcode 011) writes the selected register into the memory word at the operand address. No other memory word changes.
- R4: Subtract (opcode 101) with B not greater than A (unsigned) writes A−B into A and clears the error flag. It ignores bits [5:0].
- R5: Subtract with B greater than A writes 0 into A and sets the error flag to 1.
- R6: Jump-on-error (opcode 110) loads the operand into the program counter if the error flag is 1, and otherwise adds one. In both cases it clears the flag.
- R7: Stop (opcode 111) ignores bits [5:0] and moves the core to a halted state. In that state `halted` is 1 and the program counter, registers and flag stay unchanged until reset.
- R8: Opcodes 000, 001 and 100 halt the core with `illegal_op` = 1. The program counter stays at the offending word.
- R9: Every instruction other than a taken jump, stop or an illegal opcode advances the program counter by one, modulo 32 (31 wraps to 0).
- R10: Counted in clock cycles with the debug port idle, a load takes 5 cycles and store, subtract and jump take 4 each. The cycle that sets `halted` after a stop or an illegal opcode is the 3rd cycle of that instruction.
- R11: While `dbg_en` = 1 the core does not advance. A debug read returns its data on `dbg_rdata` one cycle after the request. `dbg_sel` = 0 addresses memory. `dbg_sel` = 1 addresses registers: 0 = A, 1 = B, 2 = PC (zero-extended), 3 = instruction register, 4 = error flag. Writes through this port are accepted to memory (also during reset) and to registers 0, 1, 2 and 4 (not during reset).
- R12: Load and store clear the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 5 | Program counter value loaded at reset |
| halted | output | 1 | High once the core has stopped |
| illegal_op | output | 1 | High when the core stopped on an undefined opcode |
| dbg_en | input | 1 | Debug access enable; freezes the core |
| dbg_we | input | 1 | Debug write strobe |
| dbg_sel | input | 1 | 0 = memory, 1 = register space |
| dbg_addr | input | 5 | Memory address or register index |
| dbg_wdata | input | 9 | Debug write data |
| dbg_rdata | output | 9 | Debug read data, one cycle after the request |

## Verification
The bench builds the core with its default 9-bit word and 5-bit address. At that size the whole memory can be preloaded and read back on every run. It also lets a random program reach the wrap from address 31 to address 0, the self-modifying stores and the saturating subtract within a few dozen instructions. Each random program is first run on an instruction-level model in the bench, and is kept only if the model halts within 40 steps. That model supplies the final memory image, the registers, the flag, the halt cause and the exact cycle count. Directed programs cover the underflow, the jump taken and not taken, the wrap, all three undefined opcodes and the freeze behaviour of the debug port.

// File: rtl/cpu9_pkg.sv
package cpu9_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 3'b010;
   localparam logic [OPC_W-1:0] OPC_STORE = 3'b011;
   localparam logic [OPC_W-1:0] OPC_SUB   = 3'b101;
   localparam logic [OPC_W-1:0] OPC_JERR  = 3'b110;
   localparam logic [OPC_W-1:0] OPC_STOP  = 3'b111;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_HALT   = 2'd3
   } state_t;

   typedef enum logic [2:0] {
      K_LOAD  = 3'd0,
      K_STORE = 3'd1,
      K_SUB   = 3'd2,
      K_JERR  = 3'd3,
      K_STOP  = 3'd4,
      K_BAD   = 3'd5
   } kind_t;

endpackage

// File: rtl/cpu9_mem.sv
module cpu9_mem #(
   parameter int DW = 9,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store_q[addr] <= wdata;
      end
      rdata <= store_q[addr];
   end
endmodule

// File: rtl/cpu9_decode.sv
module cpu9_decode
   import cpu9_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 5
) (
   input  logic [DW-1:0] ir,
   output kind_t         kind,
   output logic          reg_sel,
   output logic [AW-1:0] operand
);
   logic [OPC_W-1:0] opc;

   assign opc     = ir[DW-1 -: OPC_W];
   assign reg_sel = ir[AW];
   assign operand = ir[AW-1:0];

   always_comb begin
      unique case (opc)
         OPC_LOAD:  kind = K_LOAD;
         OPC_STORE: kind = K_STORE;
         OPC_SUB:   kind = K_SUB;
         OPC_JERR:  kind = K_JERR;
         OPC_STOP:  kind = K_STOP;
         default:   kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/cpu9_regfile.sv
module cpu9_regfile #(
   parameter int DW   = 9,
   parameter int NREG = 2,
   localparam int RSW = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [RSW-1:0]    wsel,
   input  logic [DW-1:0]     wdata,
   output logic [NREG*DW-1:0] rd_flat
);
   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (we && (wsel == RSW'(gi))) begin
            q <= wdata;
         end
      end
      assign rd_flat[gi*DW +: DW] = q;
   end
endmodule

// File: rtl/cpu9_ctrl.sv
module cpu9_ctrl
   import cpu9_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          stall,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] mem_rdata,
   input  kind_t         kind,
   input  logic          reg_sel,
   input  logic [AW-1:0] operand,
   input  logic [DW-1:0] a_val,
   input  logic [DW-1:0] b_val,
   input  logic          dbg_wr_pc,
   input  logic          dbg_wr_err,
   input  logic [AW-1:0] dbg_pc_val,
   input  logic          dbg_err_val,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          rf_we,
   output logic          rf_sel,
   output logic [DW-1:0] rf_wdata,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] ir,
   output logic          err,
   output state_t        state,
   output logic          illegal
);
   localparam logic [AW-1:0] PC_STEP = AW'(1);

   logic          phase;
   logic          under;
   logic [DW-1:0] diff;
   logic [AW-1:0] pc_next;
   logic          in_exec;

   assign under   = b_val > a_val;
   assign diff    = under ? '0 : (a_val - b_val);
   assign pc_next = pc + PC_STEP;
   assign in_exec = (state == ST_EXEC) && !stall && !rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_FETCH;
         phase   <= 1'b0;
         pc      <= start_addr;
         ir      <= '0;
         err     <= 1'b0;
         illegal <= 1'b0;
      end else if (stall) begin
         phase <= 1'b0;
         if (dbg_wr_pc) begin
            pc <= dbg_pc_val;
         end
         if (dbg_wr_err) begin
            err <= dbg_err_val;
         end
      end else begin
         unique case (state)
            ST_FETCH: begin
               if (!phase) begin
                  phase <= 1'b1;
               end else begin
                  phase <= 1'b0;
                  ir    <= mem_rdata;
                  state <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               if (kind == K_BAD) begin
                  illegal <= 1'b1;
                  state   <= ST_HALT;
               end else if (kind == K_STOP) begin
                  state <= ST_HALT;
               end else begin
                  state <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               unique case (kind)
                  K_LOAD: begin
                     if (!phase) begin
                        phase <= 1'b1;
                     end else begin
                        phase <= 1'b0;
                        err   <= 1'b0;
                        pc    <= pc_next;
                        state <= ST_FETCH;
                     end
                  end
                  K_STORE: begin
                     err   <= 1'b0;
                     pc    <= pc_next;
                     state <= ST_FETCH;
                  end
                  K_SUB: begin
                     err   <= under;
                     pc    <= pc_next;
                     state <= ST_FETCH;
                  end
                  K_JERR: begin
                     pc    <= err ? operand : pc_next;
                     err   <= 1'b0;
                     state <= ST_FETCH;
                  end
                  default: state <= ST_HALT;
               endcase
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   assign mem_addr  = (state == ST_EXEC) ? operand : pc;
   assign mem_we    = in_exec && (kind == K_STORE);
   assign mem_wdata = reg_sel ? b_val : a_val;
   assign rf_we     = in_exec && (((kind == K_LOAD) && phase) || (kind == K_SUB));
   assign rf_sel    = (kind == K_SUB) ? 1'b0 : reg_sel;
   assign rf_wdata  = (kind == K_SUB) ? diff : mem_rdata;
endmodule

// File: rtl/cpu9_core.sv
module cpu9_core
   import cpu9_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] start_addr,
   output logic          halted,
   output logic          illegal_op,
   input  logic          dbg_en,
   input  logic          dbg_we,
   input  logic          dbg_sel,
   input  logic [AW-1:0] dbg_addr,
   input  logic [DW-1:0] dbg_wdata,
   output logic [DW-1:0] dbg_rdata
);
   localparam int NREG = 2;

   if (DW != OPC_W + 1 + AW) begin : g_bad_fmt
      $error("cpu9_core: DW must equal opcode width + 1 + AW");
   end
   if (AW < 3) begin : g_bad_aw
      $error("cpu9_core: AW must be at least 3 to index the register space");
   end

   logic [AW-1:0]      core_addr, mem_addr_w, operand_w, pc_w;
   logic               core_we, mem_we_w, reg_sel_w, err_w;
   logic [DW-1:0]      core_wdata, mem_wdata_w, mem_rdata_w, ir_w;
   logic               core_rf_we, core_rf_sel, rf_we_w, rf_sel_w;
   logic [DW-1:0]      core_rf_wdata, rf_wdata_w, a_w, b_w;
   logic [NREG*DW-1:0] rd_flat_w;
   kind_t              kind_w;
   state_t             state_w;
   logic               dbg_reg_wr, dbg_wr_pc, dbg_wr_err;
   logic [DW-1:0]      reg_view, reg_view_q;
   logic               sel_q;

   assign a_w = rd_flat_w[0 +: DW];
   assign b_w = rd_flat_w[DW +: DW];

   assign dbg_reg_wr = dbg_en && dbg_we && dbg_sel && !rst;
   assign dbg_wr_pc  = dbg_reg_wr && (dbg_addr == AW'(2));
   assign dbg_wr_err = dbg_reg_wr && (dbg_addr == AW'(4));

   assign mem_addr_w  = dbg_en ? dbg_addr : core_addr;
   assign mem_we_w    = dbg_en ? (dbg_we && !dbg_sel) : core_we;
   assign mem_wdata_w = dbg_en ? dbg_wdata : core_wdata;

   assign rf_we_w    = dbg_en ? (dbg_reg_wr && (dbg_addr < AW'(NREG))) : core_rf_we;
   assign rf_sel_w   = dbg_en ? dbg_addr[0] : core_rf_sel;
   assign rf_wdata_w = dbg_en ? dbg_wdata : core_rf_wdata;

   cpu9_mem #(.DW(DW), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (mem_we_w),
      .addr  (mem_addr_w),
      .wdata (mem_wdata_w),
      .rdata (mem_rdata_w)
   );

   cpu9_decode #(.DW(DW), .AW(AW)) u_dec (
      .ir      (ir_w),
      .kind    (kind_w),
      .reg_sel (reg_sel_w),
      .operand (operand_w)
   );

   cpu9_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we_w),
      .wsel    (rf_sel_w),
      .wdata   (rf_wdata_w),
      .rd_flat (rd_flat_w)
   );

   cpu9_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .stall       (dbg_en),
      .start_addr  (start_addr),
      .mem_rdata   (mem_rdata_w),
      .kind        (kind_w),
      .reg_sel     (reg_sel_w),
      .operand     (operand_w),
      .a_val       (a_w),
      .b_val       (b_w),
      .dbg_wr_pc   (dbg_wr_pc),
      .dbg_wr_err  (dbg_wr_err),
      .dbg_pc_val  (dbg_wdata[AW-1:0]),
      .dbg_err_val (dbg_wdata[0]),
      .mem_addr    (core_addr),
      .mem_we      (core_we),
      .mem_wdata   (core_wdata),
      .rf_we       (core_rf_we),
      .rf_sel      (core_rf_sel),
      .rf_wdata    (core_rf_wdata),
      .pc          (pc_w),
      .ir          (ir_w),
      .err         (err_w),
      .state       (state_w),
      .illegal     (illegal_op)
   );

   always_comb begin
      unique case (dbg_addr)
         AW'(0):  reg_view = a_w;
         AW'(1):  reg_view = b_w;
         AW'(2):  reg_view = {{(DW-AW){1'b0}}, pc_w};
         AW'(3):  reg_view = ir_w;
         AW'(4):  reg_view = {{(DW-1){1'b0}}, err_w};
         default: reg_view = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      reg_view_q <= reg_view;
      sel_q      <= dbg_sel;
   end

   assign dbg_rdata = sel_q ? reg_view_q : mem_rdata_w;
   assign halted    = (state_w == ST_HALT);
endmodule

// File: rtl/cpu9_chk.sv
module cpu9_chk
   import cpu9_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst,
   input logic [AW-1:0] start_addr,
   input logic          halted,
   input logic          illegal_op,
   input logic          dbg_en,
   input logic          dbg_we,
   input state_t        state,
   input kind_t         kind,
   input logic [AW-1:0] pc,
   input logic          err,
   input logic [DW-1:0] a,
   input logic [DW-1:0] b
);
   // R1
   reset_load_chk: assert property (@(posedge clk)
      ($past(rst) && !rst) |-> (pc == $past(start_addr) && a == '0 && b == '0 && !err && !halted));

   // R4
   sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && kind == K_SUB && !dbg_en && b <= a) |=> (a == $past(a) - $past(b) && !err));

   // R5
   sub_clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && kind == K_SUB && !dbg_en && b > a) |=> (a == '0 && err));

   // R6
   jerr_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && kind == K_JERR && !dbg_en) |=> !err);

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc) && $stable(err)));

   // R8
   illegal_halt_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_op |-> halted);

   // R11
   freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (dbg_en && !dbg_we) |=> ($stable(pc) && $stable(a) && $stable(b) && $stable(state)));
endmodule

bind cpu9_core cpu9_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start_addr (start_addr),
   .halted     (halted),
   .illegal_op (illegal_op),
   .dbg_en     (dbg_en),
   .dbg_we     (dbg_we),
   .state      (state_w),
   .kind       (kind_w),
   .pc         (pc_w),
   .err        (err_w),
   .a          (a_w),
   .b          (b_w)
);

// File: tb/sim_cpu9_core.sv
module sim_cpu9_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] start_addr = '0;
   logic       halted, illegal_op;
   logic       dbg_en = 1'b1, dbg_we = 1'b0, dbg_sel = 1'b0;
   logic [4:0] dbg_addr = '0;
   logic [8:0] dbg_wdata = '0;
   logic [8:0] dbg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_total = 0;

   logic [8:0] prog  [32];
   logic [8:0] m_mem [32];
   logic [8:0] m_a, m_b;
   logic [4:0] m_pc;
   logic       m_err, m_halt, m_ill;
   int         m_cyc;

   always #4 clk = ~clk;

   cpu9_core u0 (
      .clk        (clk),
      .rst        (rst),
      .start_addr (start_addr),
      .halted     (halted),
      .illegal_op (illegal_op),
      .dbg_en     (dbg_en),
      .dbg_we     (dbg_we),
      .dbg_sel    (dbg_sel),
      .dbg_addr   (dbg_addr),
      .dbg_wdata  (dbg_wdata),
      .dbg_rdata  (dbg_rdata)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total == 190000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_total);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [8:0] enc(input logic [2:0] op, input logic rs, input logic [4:0] od);
      return {op, rs, od};
   endfunction

   // instruction-level model used to predict end state and cycle count
   task automatic model(input logic [4:0] start, input logic [8:0] a0, input logic [8:0] b0,
                        input logic e0, input int cap);
      logic [8:0] w;
      int steps;
      for (int i = 0; i < 32; i++) m_mem[i] = prog[i];
      m_a = a0; m_b = b0; m_pc = start; m_err = e0;
      m_halt = 1'b0; m_ill = 1'b0; m_cyc = 0; steps = 0;
      while (!m_halt && steps < cap) begin
         w = m_mem[m_pc];
         steps++;
         case (w[8:6])
            3'b010: begin
               if (w[5]) m_b = m_mem[w[4:0]]; else m_a = m_mem[w[4:0]];
               m_err = 1'b0; m_pc = m_pc + 5'd1; m_cyc += 5;
            end
            3'b011: begin
               m_mem[w[4:0]] = w[5] ? m_b : m_a;
               m_err = 1'b0; m_pc = m_pc + 5'd1; m_cyc += 4;
            end
            3'b101: begin
               if (m_b > m_a) begin m_a = '0; m_err = 1'b1; end
               else begin m_a = m_a - m_b; m_err = 1'b0; end
               m_pc = m_pc + 5'd1; m_cyc += 4;
            end
            3'b110: begin
               m_pc = m_err ? w[4:0] : m_pc + 5'd1;
               m_err = 1'b0; m_cyc += 4;
            end
            3'b111: begin m_halt = 1'b1; m_cyc += 3; end
            default: begin m_halt = 1'b1; m_ill = 1'b1; m_cyc += 3; end
         endcase
      end
   endtask

   task automatic dbg_write(input logic sel, input logic [4:0] addr, input logic [8:0] d);
      @(negedge clk);
      dbg_en = 1'b1; dbg_we = 1'b1; dbg_sel = sel; dbg_addr = addr; dbg_wdata = d;
   endtask

   task automatic dbg_read(input logic sel, input logic [4:0] addr, output logic [8:0] d);
      @(negedge clk);
      dbg_en = 1'b1; dbg_we = 1'b0; dbg_sel = sel; dbg_addr = addr;
      @(negedge clk);
      d = dbg_rdata;
   endtask

   task automatic run_prog(input logic [4:0] start, input logic [8:0] a0, input logic [8:0] b0,
                           input logic e0, input string tag);
      int cnt;
      logic [8:0] v;
      @(negedge clk);
      rst = 1'b1; start_addr = start;
      for (int i = 0; i < 32; i++) dbg_write(1'b0, 5'(i), prog[i]);
      @(negedge clk);
      dbg_we = 1'b0; rst = 1'b0;
      dbg_write(1'b1, 5'd0, a0);
      dbg_write(1'b1, 5'd1, b0);
      dbg_write(1'b1, 5'd4, {8'd0, e0});
      model(start, a0, b0, e0, 200);
      @(negedge clk);
      dbg_we = 1'b0; dbg_en = 1'b0;
      cnt = 0;
      while (!halted && cnt < 3000) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
      end
      chk(tag == "" ? "R7" : tag, "halted", 9'(halted), 9'(m_halt));
      chk(tag == "" ? "R8" : tag, "illegal_op", 9'(illegal_op), 9'(m_ill));
      chk(tag == "" ? "R10" : tag, "cycles", 9'(cnt), 9'(m_cyc));
      repeat (3) @(negedge clk);
      chk(tag == "" ? "R7" : tag, "halted held", 9'(halted), 9'd1);
      dbg_read(1'b1, 5'd0, v); chk(tag == "" ? "R2" : tag, "A", v, m_a);
      dbg_read(1'b1, 5'd1, v); chk(tag == "" ? "R2" : tag, "B", v, m_b);
      dbg_read(1'b1, 5'd2, v); chk(tag == "" ? "R9" : tag, "PC", v, {4'd0, m_pc});
      dbg_read(1'b1, 5'd4, v); chk(tag == "" ? "R6" : tag, "err", v, {8'd0, m_err});
      for (int i = 0; i < 32; i++) begin
         dbg_read(1'b0, 5'(i), v);
         chk(tag == "" ? "R3" : tag, $sformatf("mem[%0d]", i), v, m_mem[i]);
      end
   endtask

   function automatic logic [8:0] rand_word();
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 15);
      if (r <= 4) op = 3'b010;
      else if (r <= 7) op = 3'b011;
      else if (r <= 10) op = 3'b101;
      else if (r <= 12) op = 3'b110;
      else if (r == 13) op = 3'b111;
      else if (r == 14) begin
         case ($urandom_range(0, 2))
            0: op = 3'b000;
            1: op = 3'b001;
            default: op = 3'b100;
         endcase
      end else return 9'($urandom);
      return enc(op, 1'($urandom), 5'($urandom));
   endfunction

   task automatic clear_prog();
      for (int i = 0; i < 32; i++) prog[i] = 9'd0;
   endtask

   initial begin
      logic [8:0] v;
      logic [4:0] st;
      logic [8:0] ra, rb;
      logic       re;
      void'($urandom(32'd20251));

      // R12: load into B clears a preset flag
      clear_prog();
      prog[0] = enc(3'b010, 1'b1, 5'd21); prog[21] = 9'd11; prog[1] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd0, 9'd0, 9'd0, 1'b1, "R12");
      // R2: load into A
      clear_prog();
      prog[4] = enc(3'b010, 1'b0, 5'd9); prog[9] = 9'd300; prog[5] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd4, 9'd7, 9'd8, 1'b0, "R2");
      // R4: 7 - 5 = 2, flag cleared
      clear_prog();
      prog[0] = enc(3'b101, 1'b1, 5'd31); prog[1] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd0, 9'd7, 9'd5, 1'b1, "R4");
      // R5: 3 - 5 clamps to 0, flag set
      clear_prog();
      prog[0] = enc(3'b101, 1'b0, 5'd0); prog[1] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd0, 9'd3, 9'd5, 1'b0, "R5");
      // R6: jump not taken at 30 -> 31, then taken -> 5
      clear_prog();
      prog[30] = enc(3'b110, 1'b0, 5'd5); prog[31] = enc(3'b111, 1'b0, 5'd0); prog[5] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd30, 9'd1, 9'd2, 1'b0, "R6");
      run_prog(5'd30, 9'd1, 9'd2, 1'b1, "R6");
      // R9: store at 31 wraps PC to 0
      clear_prog();
      prog[31] = enc(3'b011, 1'b0, 5'd20); prog[0] = enc(3'b111, 1'b0, 5'd0);
      run_prog(5'd31, 9'd25, 9'd1, 1'b1, "R9");
      // R3: store B
      clear_prog();
      prog[2] = enc(3'b011, 1'b1, 5'd17); prog[3] = enc(3'b111, 1'b0, 5'd0); prog[17] = 9'h1FF;
      run_prog(5'd2, 9'd4, 9'd300, 1'b0, "R3");
      // R7: stop with nonzero trailing bits changes nothing
      clear_prog();
      prog[0] = enc(3'b111, 1'b1, 5'b10101);
      run_prog(5'd0, 9'd77, 9'd88, 1'b1, "R7");
      // R8: each undefined opcode
      clear_prog();
      prog[3] = enc(3'b100, 1'b1, 5'd3);
      run_prog(5'd3, 9'd1, 9'd1, 1'b0, "R8");
      prog[3] = enc(3'b000, 1'b0, 5'd1);
      run_prog(5'd3, 9'd1, 9'd1, 1'b0, "R8");
      prog[6] = enc(3'b001, 1'b1, 5'd9); prog[5] = enc(3'b101, 1'b0, 5'd0);
      run_prog(5'd5, 9'd9, 9'd2, 1'b0, "R8");

      // R1 and R11: reset state seen through the frozen debug port
      @(negedge clk);
      rst = 1'b1; dbg_en = 1'b1; dbg_we = 1'b0; start_addr = 5'd17;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1", "halted after reset", 9'(halted), 9'd0);
      chk("R1", "illegal_op after reset", 9'(illegal_op), 9'd0);
      dbg_read(1'b1, 5'd0, v); chk("R1", "A after reset", v, 9'd0);
      dbg_read(1'b1, 5'd1, v); chk("R1", "B after reset", v, 9'd0);
      dbg_read(1'b1, 5'd4, v); chk("R1", "err after reset", v, 9'd0);
      dbg_read(1'b1, 5'd2, v); chk("R1", "PC after reset", v, 9'd17);
      repeat (10) @(negedge clk);
      chk("R11", "frozen core not halted", 9'(halted), 9'd0);
      dbg_read(1'b1, 5'd2, v); chk("R11", "frozen PC", v, 9'd17);
      dbg_write(1'b1, 5'd1, 9'd123);
      dbg_read(1'b1, 5'd1, v); chk("R11", "debug write of B", v, 9'd123);
      dbg_write(1'b0, 5'd12, 9'd456);
      dbg_read(1'b0, 5'd12, v); chk("R11", "debug memory round trip", v, 9'd456);

      // random programs checked against the model
      for (int t = 0; t < 120; t++) begin
         do begin
            for (int i = 0; i < 32; i++) prog[i] = rand_word();
            st = 5'($urandom); ra = 9'($urandom); rb = 9'($urandom); re = 1'($urandom);
            model(st, ra, rb, re, 40);
         end while (!m_halt);
         run_prog(st, ra, rb, re, "");
      end

      summary();
      $finish;
   end
endmodule